// File: doc/BRIEF.md
# Load/Store Alignment Fault Checker

This block sits beside the load/store stage of a processor pipeline and judges every memory request for alignment. From the low bits of the effective address and the access size it decides whether the request is aligned. For an unaligned request it then decides whether the instruction class may proceed unaligned or must raise a usage fault. Only single word, single halfword and signed halfword loads and stores may run unaligned. A global trap control input removes that tolerance, so that every unaligned access faults.

The aligned and permitted flags are combinational with the default `REG_FLAGS = 0`. With `REG_FLAGS = 1` they are registered and arrive one cycle later. The fault strobe and the fault-cause code are always registered. The strobe pulses in the cycle after the offending request. The cause code holds its value until the next valid request. The block does not perform the memory access, split unaligned accesses into bus beats, take the exception or decode opcodes.

Top module: `lsu_align_checker`

## Requirements
- R1: A byte access (size code 0) is always reported aligned and never produces a fault, at any address.
- R2: A halfword access (size code 1) is aligned exactly when address bit 0 is 0.
- R3: Word, dual-word and multiple-word accesses (size codes 2, 3 and 4) are aligned exactly when address bits 1 and 0 are both 0.
- R4: With the trap input low, an unaligned request of class 0 (word single), 1 (halfword single) or 2 (signed halfword) drives permit_o high, produces no fault and sets cause_o to 00.
- R5: An unaligned request of class 3 (dual), 4 (multiple) or 5 (exclusive/other) faults and sets cause_o to 01, whether the trap input is high or low.
- R6: With the trap input high, an unaligned request of class 0, 1 or 2 faults with cause_o 10, and permit_o is low.
- R7: A valid aligned request drives aligned_o and permit_o high, never faults and sets cause_o to 00, whatever the trap input is.
- R8: fault_o is high in exactly the cycle after each valid request that faults, and low in every other cycle.
- R9: cause_o is updated by every valid request in the following cycle and holds its value while req_valid_i is low.
- R10: While req_valid_i is low, aligned_o and permit_o are low and no fault is raised.
- R11: Reset clears fault_o to 0 and cause_o to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| addr_i | input | 32 | Effective address |
| size_i | input | 3 | Access size: 0 byte, 1 halfword, 2 word, 3 dual, 4 multiple |
| cls_i | input | 3 | Instruction class: 0 word, 1 halfword, 2 signed halfword, 3 dual, 4 multiple, 5 exclusive/other |
| trap_all_i | input | 1 | Fault on every unaligned access |
| aligned_o | output | 1 | Request is aligned |
| permit_o | output | 1 | Request may proceed (aligned or tolerated unaligned) |
| fault_o | output | 1 | Usage-fault strobe, one cycle after the request |
| cause_o | output | 2 | 00 none, 01 class not tolerant, 10 trapped by control |

## Verification
The assertions assume that size_i holds only the codes 0 to 4 and cls_i only the codes 0 to 5 while a request is valid. Codes above those ranges are given a defined but unchecked treatment. The bench keeps every directed and random request inside those ranges: it draws the size modulo 5 and the class modulo 6. It mixes idle cycles, trap settings and all four low-address residues.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int SIZE_W  = 3;
  localparam int CLS_W   = 3;
  localparam int CAUSE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DUAL  = 3'd3,
    SZ_MULTI = 3'd4
  } acc_size_e;

  typedef enum logic [CLS_W-1:0] {
    CL_WORD  = 3'd0,
    CL_HALF  = 3'd1,
    CL_SHALF = 3'd2,
    CL_DUAL  = 3'd3,
    CL_MULTI = 3'd4,
    CL_EXCL  = 3'd5
  } acc_class_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_CLASS = 2'b01,
    CAUSE_TRAP  = 2'b10
  } cause_e;
endpackage

// File: rtl/lsu_align_decode.sv
module lsu_align_decode
  import lsu_align_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0]  addr_low_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              aligned_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: aligned_o = 1'b1;
      SZ_HALF: aligned_o = ~addr_low_i[0];
      // word, dual, multiple and unused codes need full word alignment
      default: aligned_o = ~|addr_low_i;
    endcase
  end
endmodule

// File: rtl/lsu_align_policy.sv
module lsu_align_policy
  import lsu_align_pkg::*;
#(
  parameter int                TOL_W    = 1 << CLS_W,
  parameter logic [TOL_W-1:0]  TOL_MASK = 8'b0000_0111
) (
  input  logic             valid_i,
  input  logic             aligned_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             trap_all_i,
  output logic             aligned_o,
  output logic             permit_o,
  output logic             viol_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic tolerant;
  logic unal;

  assign tolerant  = TOL_MASK[cls_i];
  assign unal      = valid_i & ~aligned_i;
  assign aligned_o = valid_i & aligned_i;
  assign permit_o  = aligned_o | (unal & tolerant & ~trap_all_i);
  assign viol_o    = unal & ~(tolerant & ~trap_all_i);

  always_comb begin
    if (!viol_o)       cause_o = CAUSE_NONE;
    else if (!tolerant) cause_o = CAUSE_CLASS;
    else               cause_o = CAUSE_TRAP;
  end
endmodule

// File: rtl/lsu_align_out.sv
module lsu_align_out
  import lsu_align_pkg::*;
#(
  parameter bit REG_FLAGS = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               aligned_i,
  input  logic               permit_i,
  input  logic               viol_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               aligned_o,
  output logic               permit_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      fault_q <= viol_i;
      if (valid_i) cause_q <= cause_i;
    end
  end

  assign fault_o = fault_q;
  assign cause_o = cause_q;

  generate
    if (REG_FLAGS) begin : g_reg
      logic aligned_q, permit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          aligned_q <= 1'b0;
          permit_q  <= 1'b0;
        end else begin
          aligned_q <= aligned_i;
          permit_q  <= permit_i;
        end
      end
      assign aligned_o = aligned_q;
      assign permit_o  = permit_q;
    end else begin : g_comb
      assign aligned_o = aligned_i;
      assign permit_o  = permit_i;
    end
  endgenerate
endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit REG_FLAGS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        cls_i,
  input  logic              trap_all_i,
  output logic              aligned_o,
  output logic              permit_o,
  output logic              fault_o,
  output logic [1:0]        cause_o
);
  localparam int LOW_W = 2;

  logic               addr_ok;
  logic               aligned_c;
  logic               permit_c;
  logic               viol_c;
  logic [CAUSE_W-1:0] cause_c;
  logic               unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-1:LOW_W];

  lsu_align_decode #(.LOW_W(LOW_W)) u_dec (
    .addr_low_i (addr_i[LOW_W-1:0]),
    .size_i     (size_i),
    .aligned_o  (addr_ok)
  );

  lsu_align_policy u_pol (
    .valid_i    (req_valid_i),
    .aligned_i  (addr_ok),
    .cls_i      (cls_i),
    .trap_all_i (trap_all_i),
    .aligned_o  (aligned_c),
    .permit_o   (permit_c),
    .viol_o     (viol_c),
    .cause_o    (cause_c)
  );

  lsu_align_out #(.REG_FLAGS(REG_FLAGS)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .aligned_i (aligned_c),
    .permit_i  (permit_c),
    .viol_i    (viol_c),
    .cause_i   (cause_c),
    .aligned_o (aligned_o),
    .permit_o  (permit_o),
    .fault_o   (fault_o),
    .cause_o   (cause_o)
  );
endmodule

// File: rtl/lsu_align_sva.sv
module lsu_align_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] addr_low,
  input logic [2:0] size_i,
  input logic [2:0] cls_i,
  input logic       trap_all_i,
  input logic       aligned_c,
  input logic       permit_c,
  input logic       fault_o,
  input logic [1:0] cause_o
);
  // R1
  byte_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && size_i == 3'd0 |=> !fault_o);
  // R3
  word_misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && size_i >= 3'd2 && size_i <= 3'd4 && addr_low != 2'b00 |-> !aligned_c);
  // R5
  class_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !aligned_c && cls_i >= 3'd3 && cls_i <= 3'd5 |=> fault_o && cause_o == 2'b01);
  // R6
  trap_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !aligned_c && trap_all_i && cls_i <= 3'd2 |=> fault_o && cause_o == 2'b10);
  // R7
  aligned_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && aligned_c |=> !fault_o && cause_o == 2'b00);
  // R8
  fault_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(req_valid_i) && !$past(permit_c));
  // R9
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(cause_o));
  // R10
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !aligned_c && !permit_c);
endmodule

bind lsu_align_checker lsu_align_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .addr_low    (addr_i[1:0]),
  .size_i      (size_i),
  .cls_i       (cls_i),
  .trap_all_i  (trap_all_i),
  .aligned_c   (aligned_c),
  .permit_c    (permit_c),
  .fault_o     (fault_o),
  .cause_o     (cause_o)
);

// File: tb/sim_lsu_align_checker.sv
module sim_lsu_align_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  size = '0;
  logic [2:0]  cls = '0;
  logic        trap = 1'b0;
  logic        aligned, permit, fault;
  logic [1:0]  cause;

  int compared = 0;
  int mismatched = 0;
  logic [1:0] held_cause = 2'b00;
  bit done = 0;

  always #2 clk = ~clk;

  lsu_align_checker u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .addr_i(addr),
    .size_i(size), .cls_i(cls), .trap_all_i(trap),
    .aligned_o(aligned), .permit_o(permit), .fault_o(fault), .cause_o(cause)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference and one request per cycle
  task automatic step(input bit v, input int a, input int s, input int c, input bit t, input string req);
    bit al, tol, pm, flt;
    int cz;
    @(negedge clk);
    vld = v; addr = a; size = 3'(s); cls = 3'(c); trap = t;
    if (s == 0)      al = 1;
    else if (s == 1) al = (a % 2) == 0;
    else             al = (a % 4) == 0;
    tol = (c <= 2);
    pm  = v && (al || (tol && !t));
    flt = v && !al && !(tol && !t);
    cz  = !flt ? 0 : (!tol ? 1 : 2);
    #1;
    chk(req, "aligned_o", int'(aligned), int'(v && al));
    chk(req, "permit_o", int'(permit), int'(pm));
    @(posedge clk);
    #1;
    if (v) held_cause = 2'(cz);
    chk(req, "fault_o", int'(fault), int'(flt));
    chk(req, "cause_o", int'(cause), int'(held_cause));
  endtask

  initial begin
    #40000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "fault_o in reset", int'(fault), 0);
    chk("R11", "cause_o in reset", int'(cause), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 byte at every residue, trap on
    for (int i = 0; i < 4; i++) step(1, 32'h100 + i, 0, 5, 1, "R1");
    // R2 halfword
    step(1, 32'h201, 1, 1, 0, "R2");
    step(1, 32'h202, 1, 1, 0, "R2");
    step(1, 32'h203, 1, 3, 0, "R2");
    // R3 word/dual/multiple
    for (int s = 2; s <= 4; s++)
      for (int i = 0; i < 4; i++) step(1, 32'h300 + i, s, 0, 0, "R3");
    // R4 tolerated classes
    step(1, 32'h401, 2, 0, 0, "R4");
    step(1, 32'h403, 1, 1, 0, "R4");
    step(1, 32'h405, 1, 2, 0, "R4");
    // R5 non-tolerant classes, trap both ways
    step(1, 32'h502, 3, 3, 0, "R5");
    step(1, 32'h506, 4, 4, 1, "R5");
    step(1, 32'h501, 2, 5, 0, "R5");
    // R6 trap on tolerated classes
    step(1, 32'h602, 2, 0, 1, "R6");
    step(1, 32'h601, 1, 2, 1, "R6");
    // R7 aligned with trap
    step(1, 32'h700, 3, 3, 1, "R7");
    step(1, 32'h702, 1, 1, 1, "R7");
    // R8 back-to-back faults then clean
    step(1, 32'h801, 2, 4, 0, "R8");
    step(1, 32'h803, 2, 1, 1, "R8");
    step(1, 32'h800, 2, 0, 0, "R8");
    // R9/R10 idle after fault keeps cause
    step(1, 32'h901, 2, 3, 0, "R9");
    step(0, 32'h903, 3, 3, 1, "R10");
    step(0, 32'h900, 2, 0, 0, "R9");
    // random mix
    for (int n = 0; n < 600; n++)
      step(($urandom % 4) != 0, int'($urandom), int'($urandom % 5), int'($urandom % 6),
           ($urandom % 3) == 0, "R8");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule